// File: doc/BRIEF.md
# Timer Channel Tick Gate and Power-of-Four Prescaler

This block is the clock front end of a timer unit. It serves up to eight timer channels, an optional OS-timer channel and a watchdog channel. Each channel picks one of three shared tick sources: the peripheral clock, the real-time clock or an external input. It divides the chosen source by a power of four and drives a tick-enable strobe for the counter logic that follows. Every source is a single-cycle enable strobe synchronous to one system clock, so no real clock is muxed or gated.

A word-addressed register port controls the block. Three shared words stop channels, start channels and report which channels are stopped. Each channel also has a control word that holds its source selection and its prescale code. A channel's control word accepts writes only while that channel is running. Software therefore starts a channel before it reconfigures it.

Top module: `tmr_clk_front`

## Requirements
- R1: After reset every present channel is stopped, every control word reads 0 and no tick is emitted. Present channels are timers 0 to NUM_TMR-1, the OS timer at position 15 when HAS_OS is set, and the watchdog at position 16.
- R2: A write to address 0 (stop-set) stops each present channel whose position bit is 1. Bits written as 0 leave the channel unchanged.
- R3: A write to address 1 (stop-clear) starts each present channel whose position bit is 1. Bits written as 0 leave the channel unchanged.
- R4: A read of address 2 returns the stop status one cycle after the read strobe. Bit p is 1 when channel p is stopped. Bits for absent channels read 0.
- R5: A write to a channel's control word at address 32+p is ignored while that channel is stopped. A write while the channel is running replaces the whole word.
- R6: Control bits [2:0] are a one-hot source select: bit 0 picks the peripheral clock (strobe input bit 0), bit 1 the RTC (bit 1) and bit 2 the external input (bit 2). When several bits are set, the lowest one wins. With none set, the channel emits no ticks.
- R7: Control bits [5:3] hold a prescale code n, and the channel divides its source by 4^n (codes 0 to 5 give divide-by 1, 4, 16, 64, 256 and 1024). Codes 6 and 7 divide by 1024.
- R8: The tick appears in the same cycle as the 4^n-th selected strobe counted from the last restart.
- R9: The prescaler restarts from zero after any accepted control write and after any change of the channel's stop bit.
- R10: A stopped channel emits no tick, even while its selected source is strobing.
- R11: A read of a control word returns bits [5:0] as last accepted, with all higher bits 0, one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | AW | Word address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, valid the cycle after rd_en_i |
| src_stb_i | input | 3 | Source strobes: peripheral clock, RTC, external |
| tick_o | output | 17 | Divided tick-enable, one bit per stop-bit position |

## Verification
The collision that matters is a stop-set write that lands in the same cycle as a strobe from the channel's selected source. The bench runs a channel with divide-by-1 and raises the strobe together with the stop-set write. It expects the tick in that cycle, because the stop takes effect at the following edge. It then expects silence on the next strobe. A control rewrite in the middle of a count is the second collision. The bench expects the count to start again, so the old count must not produce a tick at its original fourth strobe.

// File: rtl/tmr_clk_front.sv
module tmr_clk_front #(
  parameter int NUM_TMR  = 8,
  parameter bit HAS_OS   = 1'b1,
  parameter int DW       = 32,
  parameter int AW       = 6,
  parameter int MAX_CODE = 5
) (
  input  logic          clk_i,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [2:0]    src_stb_i,
  output logic [16:0]   tick_o
);
  localparam int NPOS   = 17;
  localparam int OS_POS = 15;
  localparam int WD_POS = 16;
  localparam int CW     = 2 * MAX_CODE;
  localparam int A_SET  = 0;
  localparam int A_CLR  = 1;
  localparam int A_STAT = 2;
  localparam int A_CTRL = 32;

  function automatic logic [NPOS-1:0] f_present();
    logic [NPOS-1:0] m;
    m = '0;
    for (int k = 0; k < NUM_TMR; k++) m[k] = 1'b1;
    m[OS_POS] = HAS_OS;
    m[WD_POS] = 1'b1;
    return m;
  endfunction

  localparam logic [NPOS-1:0] PRESENT = f_present();

  logic [NPOS-1:0] stop_q, stop_nxt, wmask;
  logic [5:0]      ctrl_all [NPOS];
  logic [DW-1:0]   rd_val, rdata_q;
  logic            unused_hi;

  assign wmask     = wdata_i[NPOS-1:0] & PRESENT;
  assign unused_hi = ^wdata_i[DW-1:NPOS];

  always_comb begin
    stop_nxt = stop_q;
    if (wr_en_i && addr_i == AW'(A_SET))      stop_nxt = stop_q | wmask;
    else if (wr_en_i && addr_i == AW'(A_CLR)) stop_nxt = stop_q & ~wmask;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_n) stop_q <= PRESENT;
    else        stop_q <= stop_nxt;
  end

  for (genvar p = 0; p < NPOS; p++) begin : g_ch
    if (PRESENT[p]) begin : g_on
      logic [5:0]    ctrl_q;
      logic [CW-1:0] cnt_q, lim;
      logic [2:0]    code;
      logic          wr_c, hit, restart;

      assign wr_c    = wr_en_i && (addr_i == AW'(A_CTRL + p)) && !stop_q[p];
      assign restart = wr_c || (stop_nxt[p] != stop_q[p]) || stop_q[p];
      assign code    = (ctrl_q[5:3] > 3'(MAX_CODE)) ? 3'(MAX_CODE) : ctrl_q[5:3];
      assign lim     = ~({CW{1'b1}} << (2 * code));
      assign hit     = !stop_q[p] && (ctrl_q[0] ? src_stb_i[0] :
                                      ctrl_q[1] ? src_stb_i[1] :
                                      (ctrl_q[2] && src_stb_i[2]));

      always_ff @(posedge clk_i) begin
        if (!rst_n)    ctrl_q <= '0;
        else if (wr_c) ctrl_q <= wdata_i[5:0];
      end

      always_ff @(posedge clk_i) begin
        if (!rst_n || restart) cnt_q <= '0;
        else if (hit)          cnt_q <= (cnt_q == lim) ? '0 : cnt_q + 1'b1;
      end

      assign tick_o[p]   = hit && (cnt_q == lim);
      assign ctrl_all[p] = ctrl_q;
    end else begin : g_off
      assign tick_o[p]   = 1'b0;
      assign ctrl_all[p] = '0;
    end
  end

  always_comb begin
    rd_val = '0;
    if (addr_i == AW'(A_STAT)) rd_val = DW'(stop_q);
    for (int k = 0; k < NPOS; k++)
      if (addr_i == AW'(A_CTRL + k)) rd_val = DW'(ctrl_all[k]);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_n)       rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_val;
    else              rdata_q <= '0;
  end

  assign rdata_o = rdata_q;
endmodule

module tmr_clk_front_chk #(
  parameter int              DW      = 32,
  parameter int              AW      = 6,
  parameter int              NPOS    = 17,
  parameter logic [NPOS-1:0] PRESENT = '1
) (
  input logic            clk_i,
  input logic            rst_n,
  input logic            wr_en_i,
  input logic            rd_en_i,
  input logic [AW-1:0]   addr_i,
  input logic [DW-1:0]   wdata_i,
  input logic [DW-1:0]   rdata_o,
  input logic [2:0]      src_stb_i,
  input logic [16:0]     tick_o,
  input logic [NPOS-1:0] stop_q
);
  a_r10_stopped_silent: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tick_o & stop_q) == '0);

  a_r8_tick_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_n)
    (|tick_o) |-> (|src_stb_i));

  a_r2_set_stops: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && addr_i == AW'(0)) |=>
      ((stop_q & $past(wdata_i[NPOS-1:0]) & PRESENT) == ($past(wdata_i[NPOS-1:0]) & PRESENT)));

  a_r3_clear_starts: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && addr_i == AW'(1)) |=>
      ((stop_q & $past(wdata_i[NPOS-1:0])) == '0));

  a_r4_status_read: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_en_i && addr_i == AW'(2)) |=> (rdata_o[NPOS-1:0] == $past(stop_q)));
endmodule

bind tmr_clk_front tmr_clk_front_chk #(
  .DW(DW), .AW(AW), .NPOS(NPOS), .PRESENT(PRESENT)
) u_chk (
  .clk_i(clk_i), .rst_n(rst_n), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
  .src_stb_i(src_stb_i), .tick_o(tick_o), .stop_q(stop_q)
);

// File: tb/tmr_clk_front_bench.sv
`timescale 1ns/1ps
module tmr_clk_front_bench;
  logic        clk_i = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [2:0]  src_stb_i = '0;
  logic [16:0] tick_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  tmr_clk_front u_tmr_clk_front (.*);

  typedef struct packed {
    logic [4:0]  ch;
    logic [5:0]  ctrl;
    logic [1:0]  src;
    logic [11:0] n;
    logic [7:0]  exp;
  } vec_t;

  localparam vec_t TBL [11] = '{
    '{5'd0,  6'h01, 2'd0, 12'd5,    8'd5},
    '{5'd1,  6'h0A, 2'd1, 12'd9,    8'd2},
    '{5'd2,  6'h14, 2'd2, 12'd33,   8'd2},
    '{5'd3,  6'h19, 2'd0, 12'd130,  8'd2},
    '{5'd15, 6'h24, 2'd2, 12'd600,  8'd2},
    '{5'd16, 6'h2A, 2'd1, 12'd2100, 8'd2},
    '{5'd4,  6'h3C, 2'd2, 12'd1100, 8'd1},
    '{5'd5,  6'h0E, 2'd2, 12'd8,    8'd0},
    '{5'd6,  6'h0E, 2'd1, 12'd8,    8'd2},
    '{5'd7,  6'h00, 2'd0, 12'd4,    8'd0},
    '{5'd0,  6'h01, 2'd1, 12'd4,    8'd0}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk_i); wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i); wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk_i); rd_en_i = 1'b1; addr_i = a;
    @(negedge clk_i); rd_en_i = 1'b0; d = rdata_o;
  endtask

  task automatic pulse(input int ch, input int src, input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); src_stb_i = 3'(1 << src);
      #1 if (tick_o[ch]) cnt++;
    end
    @(negedge clk_i); src_stb_i = '0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int c;
    repeat (3) @(negedge clk_i);
    rst_n = 1'b1;

    // R1, R4: reset status
    rd(6'd2, d);
    chk(d == 32'h000180FF, "R1/R4 reset status", d, 32'h000180FF);
    rd(6'd32, d);
    chk(d == 0, "R1 reset ctrl", d, 0);

    // R5, R10: stopped channel ignores writes and strobes
    wr(6'd32, 32'h01);
    rd(6'd32, d);
    chk(d == 0, "R5 write while stopped ignored", d, 0);
    pulse(0, 0, 4, c);
    chk(c == 0, "R10 stopped no ticks", c, 0);

    // R2, R3: zero bits have no effect
    wr(6'd1, 32'h3);
    rd(6'd2, d);
    chk(d == 32'h000180FC, "R3 stop-clear", d, 32'h000180FC);
    wr(6'd0, 32'h1);
    rd(6'd2, d);
    chk(d == 32'h000180FD, "R2 stop-set zeros ignored", d, 32'h000180FD);
    wr(6'd1, 32'h0);
    rd(6'd2, d);
    chk(d == 32'h000180FD, "R3 stop-clear zeros ignored", d, 32'h000180FD);

    // R9: restart on control rewrite and on stop toggle (ch1 running)
    wr(6'd33, 32'h0A);
    pulse(1, 1, 3, c);
    wr(6'd33, 32'h0A);
    pulse(1, 1, 3, c);
    chk(c == 0, "R9 restart after ctrl write", c, 0);
    pulse(1, 1, 1, c);
    chk(c == 1, "R9 tick after full count", c, 1);
    pulse(1, 1, 2, c);
    wr(6'd0, 32'h2);
    wr(6'd1, 32'h2);
    pulse(1, 1, 3, c);
    chk(c == 0, "R9 restart after stop toggle", c, 0);

    // R8, R10: stop-set in same cycle as strobe
    wr(6'd33, 32'h01);
    @(negedge clk_i); wr_en_i = 1'b1; addr_i = 6'd0; wdata_i = 32'h2; src_stb_i = 3'b001;
    #1 chk(tick_o[1] == 1'b1, "R8 tick in collision cycle", tick_o[1], 1);
    @(negedge clk_i); wr_en_i = 1'b0; wdata_i = '0;
    #1 chk(tick_o[1] == 1'b0, "R10 no tick after stop", tick_o[1], 0);
    @(negedge clk_i); src_stb_i = '0;

    // R11: readback width
    wr(6'd1, 32'h4);
    wr(6'd34, 32'hFFFF);
    rd(6'd34, d);
    chk(d == 32'h3F, "R11 ctrl readback", d, 32'h3F);
    wr(6'd0, 32'h4);

    // R6, R7, R8: table of divide cases
    for (int i = 0; i < 11; i++) begin
      wr(6'd1, 32'(1) << TBL[i].ch);
      wr(6'(32 + int'(TBL[i].ch)), 32'(TBL[i].ctrl));
      pulse(int'(TBL[i].ch), int'(TBL[i].src), int'(TBL[i].n), c);
      chk(c == int'(TBL[i].exp), "R6/R7/R8 table ticks", c, TBL[i].exp);
      wr(6'd0, 32'(1) << TBL[i].ch);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule